// File: doc/BRIEF.md
# Two-Level Segment/Page Translation Walker

This block turns a virtual address into a physical address in two steps. The top bits of the address pick one entry of a small segment table. That table is supplied as a flat register bus from outside the block. The entry gives the physical start of that segment's page table and the table's length in pages. The walker checks the page number against that length. If the page is in range, it fetches one page-table entry through a single-beat memory read port whose answer may come back after any number of cycles. It then checks the entry's valid and write-permission flags and returns either a physical address or a fault with a cause code.

The walker handles one translation at a time. A requester raises `req_valid` while `req_ready` is high, then waits for the one-cycle `done_valid` pulse that carries the result. Frame sizes are a power of two, so the physical address is the frame number from the entry with the page offset placed below it.

Top module: `pseg_walker`

## Requirements
- R1: After reset, `req_ready` is 1 and `mem_req`, `done_valid` and `done_fault` are 0.
- R2: The virtual address (16 bits by default) splits, from the top down, into a segment number of 2 bits [15:14], a page number of 6 bits [13:8] and a byte offset of 8 bits [7:0].
- R3: A page number greater than or equal to the selected segment's bound finishes the walk with cause 1. No memory read is issued.
- R4: Segment entry i occupies `seg_table[i*27 +: 27]`, with the page-table base in bits [19:0] and the bound (in pages, 0 to 64) in bits [26:20]. An in-range walk issues exactly one read at address base + page number * 2.
- R5: `mem_req` is a one-cycle pulse. The walker then waits for `mem_ack` for any number of cycles and takes `mem_rdata` in the cycle `mem_ack` is high.
- R6: A page-table entry whose valid bit (bit 12) is 0 finishes the walk with cause 2.
- R7: A write to a valid entry whose writable bit (bit 13) is 0 finishes with cause 3. Reads of such pages succeed. An invalid entry reports cause 2 even on a write.
- R8: A walk with no fault reports cause 0, `done_fault` = 0 and `done_pa` = {entry bits [11:0], offset}. A faulting walk reports `done_fault` = 1 and `done_pa` = 0.
- R9: `req_ready` is high only while no walk is in progress. Requests presented while it is low are ignored and do not change the current walk's result.
- R10: `done_valid` is high for exactly one cycle per accepted request, and `req_ready` returns in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_addr | input | 16 | Virtual address to translate |
| req_write | input | 1 | 1 for a store access, 0 for a load |
| req_ready | output | 1 | Walker idle, request is taken this cycle |
| seg_table | input | 108 | Four packed segment entries (base, bound) |
| mem_req | output | 1 | Page-table read request pulse |
| mem_addr | output | 20 | Byte address of the page-table entry |
| mem_ack | input | 1 | Read data valid |
| mem_rdata | input | 14 | Page-table entry {writable, valid, frame[11:0]} |
| done_valid | output | 1 | Result pulse |
| done_fault | output | 1 | Walk ended in a fault |
| done_cause | output | 2 | 0 none, 1 beyond bound, 2 invalid entry, 3 write to read-only |
| done_pa | output | 20 | Physical address, zero on a fault |

## Verification
The bench sweeps every page number of all four segments, once as a read and once as a write. The segments have bounds of 64, 10, 0 and 33, so the sweep covers a full segment, an empty one and both sides of each bound edge. Entries come from an arithmetic pattern that mixes valid, invalid, writable and read-only pages. This separates the bound fault from the two entry faults, and read-only reads from read-only writes. The memory answers after one to four cycles in rotation, which shows the walker waits for the acknowledge instead of a fixed delay. On some walks a different request is held on the input while the walk runs; a result for the wrong address would show that the input was taken mid-walk.

// File: rtl/pseg_pkg.sv
package pseg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEG_CHECK,
    ST_PTE_READ,
    ST_PTE_WAIT,
    ST_DONE
  } walk_state_t;

  typedef enum logic [1:0] {
    CAUSE_NONE    = 2'd0,
    CAUSE_BOUND   = 2'd1,
    CAUSE_INVALID = 2'd2,
    CAUSE_WPROT   = 2'd3
  } fault_cause_t;
endpackage

// File: rtl/pseg_seg_lookup.sv
// Selects a segment entry, checks the page number against its bound and
// forms the byte address of the page-table entry.
module pseg_seg_lookup #(
  parameter int SEG_W    = 2,
  parameter int VPN_W    = 6,
  parameter int PA_W     = 20,
  parameter int ENT_LOG2 = 1
) (
  input  logic [(1<<SEG_W)*(PA_W+VPN_W+1)-1:0] seg_table,
  input  logic [SEG_W-1:0]                     seg,
  input  logic [VPN_W-1:0]                     vpn,
  output logic                                 out_of_bound,
  output logic [PA_W-1:0]                      pte_addr
);
  localparam int NSEG  = 1 << SEG_W;
  localparam int BND_W = VPN_W + 1;
  localparam int ENT_W = PA_W + BND_W;

  logic [PA_W-1:0]  bases  [NSEG];
  logic [BND_W-1:0] bounds [NSEG];

  generate
    for (genvar i = 0; i < NSEG; i++) begin : g_ent
      assign bases[i]  = seg_table[i*ENT_W +: PA_W];
      assign bounds[i] = seg_table[i*ENT_W + PA_W +: BND_W];
    end
  endgenerate

  function automatic logic [PA_W-1:0] entry_addr(input logic [PA_W-1:0] base,
                                                 input logic [VPN_W-1:0] idx);
    logic [PA_W-1:0] scaled;
    scaled = '0;
    scaled[VPN_W+ENT_LOG2-1:ENT_LOG2] = idx;
    return base + scaled;
  endfunction

  function automatic logic beyond(input logic [BND_W-1:0] bnd,
                                  input logic [VPN_W-1:0] idx);
    return {1'b0, idx} >= bnd;
  endfunction

  assign out_of_bound = beyond(bounds[seg], vpn);
  assign pte_addr     = entry_addr(bases[seg], vpn);
endmodule

// File: rtl/pseg_pte_check.sv
// Decodes a fetched page-table entry, ranks its faults and builds the
// physical address by placing the offset under the frame number.
module pseg_pte_check
  import pseg_pkg::*;
#(
  parameter int FRAME_W = 12,
  parameter int OFF_W   = 8
) (
  input  logic [FRAME_W+1:0]       pte,
  input  logic                     is_write,
  input  logic [OFF_W-1:0]         offset,
  output fault_cause_t             cause,
  output logic [FRAME_W+OFF_W-1:0] pa
);
  localparam int VBIT = FRAME_W;
  localparam int WBIT = FRAME_W + 1;

  function automatic fault_cause_t rank(input logic valid, input logic writable,
                                        input logic wr);
    if (!valid)               return CAUSE_INVALID;
    else if (wr && !writable) return CAUSE_WPROT;
    else                      return CAUSE_NONE;
  endfunction

  assign cause = rank(pte[VBIT], pte[WBIT], is_write);
  assign pa    = {pte[FRAME_W-1:0], offset};
endmodule

// File: rtl/pseg_walker.sv
module pseg_walker
  import pseg_pkg::*;
#(
  parameter int SEG_W    = 2,
  parameter int VPN_W    = 6,
  parameter int OFF_W    = 8,
  parameter int FRAME_W  = 12,
  parameter int ENT_LOG2 = 1
) (
  input  logic                                         clk,
  input  logic                                         rst_n,
  input  logic                                         req_valid,
  input  logic [SEG_W+VPN_W+OFF_W-1:0]                 req_addr,
  input  logic                                         req_write,
  output logic                                         req_ready,
  input  logic [(1<<SEG_W)*(FRAME_W+OFF_W+VPN_W+1)-1:0] seg_table,
  output logic                                         mem_req,
  output logic [FRAME_W+OFF_W-1:0]                     mem_addr,
  input  logic                                         mem_ack,
  input  logic [FRAME_W+1:0]                           mem_rdata,
  output logic                                         done_valid,
  output logic                                         done_fault,
  output logic [1:0]                                   done_cause,
  output logic [FRAME_W+OFF_W-1:0]                     done_pa
);
  localparam int VA_W = SEG_W + VPN_W + OFF_W;
  localparam int PA_W = FRAME_W + OFF_W;

  walk_state_t     state;
  logic [VA_W-1:0] va_q;
  logic            wr_q;
  logic [PA_W-1:0] pte_addr_q;
  fault_cause_t    cause_q;
  logic [PA_W-1:0] pa_q;

  // Named internal events
  logic            seg_oob;
  logic [PA_W-1:0] seg_pte_addr;
  fault_cause_t    pte_cause;
  logic [PA_W-1:0] pte_pa;
  logic            accept;
  logic            pte_arrive;

  pseg_seg_lookup #(
    .SEG_W(SEG_W), .VPN_W(VPN_W), .PA_W(PA_W), .ENT_LOG2(ENT_LOG2)
  ) u_seg (
    .seg_table   (seg_table),
    .seg         (va_q[VA_W-1 -: SEG_W]),
    .vpn         (va_q[OFF_W +: VPN_W]),
    .out_of_bound(seg_oob),
    .pte_addr    (seg_pte_addr)
  );

  pseg_pte_check #(
    .FRAME_W(FRAME_W), .OFF_W(OFF_W)
  ) u_pte (
    .pte     (mem_rdata),
    .is_write(wr_q),
    .offset  (va_q[OFF_W-1:0]),
    .cause   (pte_cause),
    .pa      (pte_pa)
  );

  assign accept     = (state == ST_IDLE) && req_valid;
  assign pte_arrive = (state == ST_PTE_WAIT) && mem_ack;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      va_q       <= '0;
      wr_q       <= 1'b0;
      pte_addr_q <= '0;
      cause_q    <= CAUSE_NONE;
      pa_q       <= '0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          va_q  <= req_addr;
          wr_q  <= req_write;
          state <= ST_SEG_CHECK;
        end
        ST_SEG_CHECK: if (seg_oob) begin
          cause_q <= CAUSE_BOUND;
          pa_q    <= '0;
          state   <= ST_DONE;
        end else begin
          pte_addr_q <= seg_pte_addr;
          state      <= ST_PTE_READ;
        end
        ST_PTE_READ: state <= ST_PTE_WAIT;
        ST_PTE_WAIT: if (pte_arrive) begin
          cause_q <= pte_cause;
          pa_q    <= (pte_cause == CAUSE_NONE) ? pte_pa : '0;
          state   <= ST_DONE;
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready  = (state == ST_IDLE);
  assign mem_req    = (state == ST_PTE_READ);
  assign mem_addr   = pte_addr_q;
  assign done_valid = (state == ST_DONE);
  assign done_fault = done_valid && (cause_q != CAUSE_NONE);
  assign done_cause = cause_q;
  assign done_pa    = pa_q;
endmodule

// File: rtl/pseg_walker_chk.sv
module pseg_walker_chk #(
  parameter int PA_W = 20
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic            mem_req,
  input logic            done_valid,
  input logic            done_fault,
  input logic [1:0]      done_cause,
  input logic [PA_W-1:0] done_pa
);
  // R9
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R5
  mem_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  // R4
  mem_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (!req_ready && !done_valid));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> (!done_valid && req_ready));

  // R8
  fault_pa_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && done_fault) |-> (done_pa == '0 && done_cause != 2'd0));

  // R8
  clean_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && !done_fault) |-> (done_cause == 2'd0));
endmodule

bind pseg_walker pseg_walker_chk #(.PA_W(PA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .mem_req   (mem_req),
  .done_valid(done_valid),
  .done_fault(done_fault),
  .done_cause(done_cause),
  .done_pa   (done_pa)
);

// File: tb/sim_pseg_walker.sv
`timescale 1ns/1ps
module sim_pseg_walker;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic [15:0]  req_addr = '0;
  logic         req_write = 1'b0;
  logic         req_ready;
  logic [107:0] seg_table;
  logic         mem_req;
  logic [19:0]  mem_addr;
  logic         mem_ack = 1'b0;
  logic [13:0]  mem_rdata = '0;
  logic         done_valid, done_fault;
  logic [1:0]   done_cause;
  logic [19:0]  done_pa;

  pseg_walker u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_write(req_write), .req_ready(req_ready), .seg_table(seg_table),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .done_valid(done_valid), .done_fault(done_fault),
    .done_cause(done_cause), .done_pa(done_pa)
  );

  int n_checks = 0;
  int n_errors = 0;

  function automatic int seg_base(int s);
    return s * 32'h80;
  endfunction
  function automatic int seg_bound(int s);
    case (s)
      0: return 64;
      1: return 10;
      2: return 0;
      default: return 33;
    endcase
  endfunction

  // R4: entry i = {bound[6:0], base[19:0]}
  initial begin
    for (int s = 0; s < 4; s++) begin
      seg_table[s*27 +: 20] = 20'(seg_base(s));
      seg_table[s*27+20 +: 7] = 7'(seg_bound(s));
    end
  end

  // Page-table contents: word w of memory
  function automatic logic [13:0] pte_word(int w);
    logic [13:0] e;
    e[11:0] = 12'((w * 37 + 5) % 4096);
    e[12]   = (w % 5) != 0;
    e[13]   = (w % 3) == 0;
    return e;
  endfunction

  // Memory model with rotating latency of 1..4 cycles
  int          mreq_total = 0;
  logic [19:0] mreq_last = '0;
  logic        pend = 1'b0;
  int          cnt = 0;
  always @(posedge clk) begin
    mem_ack <= 1'b0;
    if (mem_req) begin
      pend       <= 1'b1;
      cnt        <= 1 + (mreq_total % 4);
      mreq_last  <= mem_addr;
      mreq_total <= mreq_total + 1;
    end else if (pend) begin
      if (cnt == 1) begin
        mem_ack   <= 1'b1;
        mem_rdata <= pte_word(int'(mreq_last[8:1]));
        pend      <= 1'b0;
      end else begin
        cnt <= cnt - 1;
      end
    end
  end

  int cycles = 0;
  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 200000) begin
      n_errors = n_errors + 1;
      $display("FAIL watchdog: actual %0d cycles expected below 200000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_checks = n_checks + 1;
    if (!ok) begin
      n_errors = n_errors + 1;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic walk(input int s, input int vpn, input int off, input bit wr,
                      input bit busy_noise);
    int  start_req, exp_cause, exp_pa, w, waited;
    bit  seen;
    logic [13:0] e;
    // expected result from the requirements
    exp_pa = 0;
    w = (seg_base(s) + vpn * 2) / 2;
    if (vpn >= seg_bound(s)) exp_cause = 1;
    else begin
      e = pte_word(w);
      if (!e[12]) exp_cause = 2;
      else if (wr && !e[13]) exp_cause = 3;
      else begin exp_cause = 0; exp_pa = int'(e[11:0]) * 256 + off; end
    end
    start_req = mreq_total;
    @(negedge clk);
    chk(req_ready == 1'b1, "R9", "ready before request", req_ready, 1);
    req_valid = 1'b1;
    req_addr  = 16'((s << 14) | (vpn << 8) | off);
    req_write = wr;
    @(negedge clk);
    if (busy_noise) begin
      req_addr  = ~req_addr;
      req_write = ~wr;
      chk(req_ready == 1'b0, "R9", "ready while busy", req_ready, 0);
    end else begin
      req_valid = 1'b0;
    end
    seen = 1'b0;
    waited = 0;
    while (!seen && waited < 40) begin
      if (done_valid) seen = 1'b1;
      else begin @(negedge clk); waited++; end
    end
    req_valid = 1'b0;
    chk(seen, "R10", "done pulse seen", seen, 1);
    chk(done_cause == 2'(exp_cause), "R3 R6 R7", "cause", done_cause, exp_cause);
    chk(done_fault == (exp_cause != 0), "R8", "fault flag", done_fault, exp_cause != 0);
    chk(done_pa == 20'(exp_pa), "R8", "physical address", done_pa, exp_pa);
    if (exp_cause == 1)
      chk(mreq_total == start_req, "R3", "reads on bound fault", mreq_total - start_req, 0);
    else begin
      chk(mreq_total == start_req + 1, "R4", "reads per walk", mreq_total - start_req, 1);
      chk(mreq_last == 20'(seg_base(s) + vpn * 2), "R2 R4", "entry address",
          mreq_last, seg_base(s) + vpn * 2);
    end
    @(negedge clk);
    chk(done_valid == 1'b0, "R10", "done after pulse", done_valid, 0);
    chk(req_ready == 1'b1, "R10", "ready after pulse", req_ready, 1);
    chk(!mem_req, "R5", "no stray read", mem_req, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R1", "reset ready", req_ready, 1);
    chk(mem_req == 1'b0, "R1", "reset mem_req", mem_req, 0);
    chk(done_valid == 1'b0, "R1", "reset done_valid", done_valid, 0);
    chk(done_fault == 1'b0, "R1", "reset done_fault", done_fault, 0);
    rst_n = 1'b1;
    for (int s = 0; s < 4; s++)
      for (int vpn = 0; vpn < 64; vpn++)
        for (int wr = 0; wr < 2; wr++)
          walk(s, vpn, (vpn * 13 + s * 7 + wr * 101) % 256, wr[0], (vpn % 8) == 3);
    // Offset extremes on one writable valid page (R8)
    walk(0, 3, 0, 1'b0, 1'b0);
    walk(0, 3, 255, 1'b1, 1'b0);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule